// File: doc/BRIEF.md
# MSI Snooping Cache Controller

This block is the coherence engine of one processor's private cache in a shared-bus multiprocessor. The cache is direct-mapped, holds one data word per line, writes back and allocates on writes. Each line is in one of three states: Invalid, Shared (clean and read-only), or Exclusive (the only copy, writable and dirty). Processor accesses that need coherence action become transactions on an atomic shared bus. Transactions from other processors are watched on a snoop port and change the local line state.

On the bus side the controller raises a request and holds command, address and data until it is granted. The transaction completes in the granted cycle. When a snooped miss hits a dirty line, the controller drives the line's data and raises an abort in the same cycle, so memory's response is replaced by the cache's copy. Snoop handling always takes precedence over the processor side. A snoop that changes the line a pending request depends on makes that request start again from its lookup.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_done`, `bus_req` and `snp_abort` are low, and a snoop to any address raises no abort.
- R2: A processor read of an Invalid line, or of a line holding another tag, issues a read miss (`bus_cmd` = 1) at the requested address. The line becomes Shared and the processor receives the bus data.
- R3: A processor write to an Invalid or Shared line issues a write miss (`bus_cmd` = 2) at the requested address. The line becomes Exclusive and holds the written word, which later reads return.
- R4: A read of a Shared or Exclusive line and a write of an Exclusive line with a matching tag complete with no bus transaction. Every access ends with `cpu_done` high for exactly one cycle, `cpu_rdata` valid on reads.
- R5: A miss that maps onto an Exclusive line holding another tag first issues a write-back (`bus_cmd` = 3) carrying the old tag, index and data. The read or write miss follows.
- R6: Replacing a Shared line issues only the new miss, with no write-back.
- R7: A snooped read miss (`snp_wr` = 0) to an Exclusive line raises `snp_abort` and drives the line data on `snp_data` in the same cycle. The line becomes Shared: a later read hits, and a later write issues a write miss.
- R8: A snooped write miss (`snp_wr` = 1) to an Exclusive line raises `snp_abort` with the line data and invalidates the line. The same snoop to a Shared line invalidates it with no abort.
- R9: A snoop to an Invalid line, to a line with another tag, or a snooped read miss to a Shared line raises no abort and leaves the line unchanged.
- R10: In any cycle with `snp_valid` high, `bus_req` is low and the processor side does not advance.
- R11: If a snoop changes the line a waiting request depends on, the request restarts from lookup. A write-back made unnecessary by the snoop is not issued.
- R12: `bus_cmd` is 0 exactly when `bus_req` is low. An ungranted request keeps `bus_cmd` and `bus_addr` stable until granted, unless a snoop intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address; low IDXW bits select the line |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write-back data |
| bus_rdata | input | DW | Data returned in a granted miss cycle |
| snp_valid | input | 1 | Another master's miss is on the bus |
| snp_wr | input | 1 | Snooped miss is a write miss |
| snp_addr | input | AW | Snooped address |
| snp_abort | output | 1 | Cancels memory's response; cache supplies data |
| snp_data | output | DW | Dirty line data supplied with the abort |

## Verification
The hardest situation to reach is a snooped write miss arriving while the controller waits for the grant to write back a dirty victim. Here the snoop both supplies the victim's data and makes the pending write-back obsolete. The bench gates the grant with a switch it holds low and starts a read that must evict an Exclusive line. It confirms the write-back request is up and stays held, then injects the snoop to the victim's address. Once the grant is released, the only transaction that follows must be the read miss.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
   typedef enum logic [1:0] {
      LS_INV = 2'd0,
      LS_SHD = 2'd1,
      LS_EXC = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      BC_IDLE   = 2'd0,
      BC_RDMISS = 2'd1,
      BC_WRMISS = 2'd2,
      BC_WBACK  = 2'd3
   } bus_cmd_t;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_WBACK = 2'd1,
      FS_MISS  = 2'd2,
      FS_RESP  = 2'd3
   } fsm_st_t;
endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
module msi_line_store
   import msi_pkg::*;
#(
   parameter int IDXW          = 3,
   parameter int TAGW          = 5,
   parameter int DW            = 16,
   parameter bit CLEAR_PAYLOAD = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   // processor-side read port
   input  logic [IDXW-1:0] a_idx,
   output line_st_t        a_state,
   output logic [TAGW-1:0] a_tag,
   output logic [DW-1:0]   a_data,
   // snoop-side read port
   input  logic [IDXW-1:0] b_idx,
   output line_st_t        b_state,
   output logic [TAGW-1:0] b_tag,
   output logic [DW-1:0]   b_data,
   // snoop state update (wins over processor update)
   input  logic            s_en,
   input  logic [IDXW-1:0] s_idx,
   input  line_st_t        s_state,
   // processor-side update
   input  logic            c_en,
   input  logic [IDXW-1:0] c_idx,
   input  line_st_t        c_state,
   input  logic [TAGW-1:0] c_tag,
   input  logic            c_data_en,
   input  logic [DW-1:0]   c_data
);
   localparam int LINES = 1 << IDXW;

   line_st_t        st_q  [LINES];
   logic [TAGW-1:0] tag_q [LINES];
   logic [DW-1:0]   dat_q [LINES];

   logic c_state_ok;
   assign c_state_ok = c_en && !(s_en && (s_idx == c_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
      end else begin
         if (s_en)       st_q[s_idx] <= s_state;
         if (c_state_ok) st_q[c_idx] <= c_state;
      end
   end

   generate
      if (CLEAR_PAYLOAD) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < LINES; i++) begin
                  tag_q[i] <= '0;
                  dat_q[i] <= '0;
               end
            end else begin
               if (c_en)              tag_q[c_idx] <= c_tag;
               if (c_en && c_data_en) dat_q[c_idx] <= c_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (c_en)              tag_q[c_idx] <= c_tag;
            if (c_en && c_data_en) dat_q[c_idx] <= c_data;
         end
      end
   endgenerate

   assign a_state = st_q[a_idx];
   assign a_tag   = tag_q[a_idx];
   assign a_data  = dat_q[a_idx];
   assign b_state = st_q[b_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_data  = dat_q[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
`timescale 1ns/1ps
module msi_snoop_unit
   import msi_pkg::*;
#(
   parameter int TAGW = 5,
   parameter int DW   = 16
) (
   input  logic            snp_valid,
   input  logic            snp_wr,
   input  logic [TAGW-1:0] snp_tag,
   input  line_st_t        line_state,
   input  logic [TAGW-1:0] line_tag,
   input  logic [DW-1:0]   line_data,
   output logic            abort,
   output logic [DW-1:0]   data,
   output logic            upd_en,
   output line_st_t        upd_state
);
   logic held;
   assign held = snp_valid && (line_state != LS_INV) && (line_tag == snp_tag);

   always_comb begin
      abort     = 1'b0;
      upd_en    = 1'b0;
      upd_state = line_state;
      if (held && line_state == LS_EXC) begin
         abort     = 1'b1;
         upd_en    = 1'b1;
         upd_state = snp_wr ? LS_INV : LS_SHD;
      end else if (held && snp_wr) begin
         upd_en    = 1'b1;
         upd_state = LS_INV;
      end
   end

   assign data = abort ? line_data : '0;
endmodule

// File: rtl/msi_req_fsm.sv
`timescale 1ns/1ps
module msi_req_fsm
   import msi_pkg::*;
#(
   parameter int AW   = 8,
   parameter int IDXW = 3,
   parameter int TAGW = 5,
   parameter int DW   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_req,
   input  logic            cpu_we,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic [DW-1:0]   cpu_rdata,
   output logic            cpu_done,
   input  line_st_t        line_state,
   input  logic [TAGW-1:0] line_tag,
   input  logic [DW-1:0]   line_data,
   input  logic            snp_valid,
   input  logic            snp_upd_en,
   input  logic [IDXW-1:0] snp_idx,
   output logic            bus_req,
   input  logic            bus_gnt,
   output bus_cmd_t        bus_cmd,
   output logic [AW-1:0]   bus_addr,
   output logic [DW-1:0]   bus_wdata,
   input  logic [DW-1:0]   bus_rdata,
   output logic            c_en,
   output line_st_t        c_state,
   output logic [TAGW-1:0] c_tag,
   output logic            c_data_en,
   output logic [DW-1:0]   c_data
);
   fsm_st_t st_q, st_d;
   logic [DW-1:0] rdata_q, rdata_d;
   logic          rd_load;

   logic [IDXW-1:0] cpu_idx;
   logic [TAGW-1:0] cpu_tag;
   logic            tag_match, is_hit, need_wb, pend_hit;

   assign cpu_idx   = cpu_addr[IDXW-1:0];
   assign cpu_tag   = cpu_addr[AW-1:IDXW];
   assign tag_match = (line_state != LS_INV) && (line_tag == cpu_tag);
   assign is_hit    = tag_match && (!cpu_we || line_state == LS_EXC);
   assign need_wb   = (line_state == LS_EXC) && (line_tag != cpu_tag);
   assign pend_hit  = snp_upd_en && (snp_idx == cpu_idx);

   always_comb begin
      st_d      = st_q;
      rdata_d   = rdata_q;
      rd_load   = 1'b0;
      bus_req   = 1'b0;
      bus_cmd   = BC_IDLE;
      bus_addr  = '0;
      bus_wdata = '0;
      c_en      = 1'b0;
      c_state   = line_state;
      c_tag     = line_tag;
      c_data_en = 1'b0;
      c_data    = cpu_wdata;
      case (st_q)
         FS_IDLE: begin
            if (cpu_req && !snp_valid) begin
               if (is_hit) begin
                  rd_load = 1'b1;
                  rdata_d = cpu_we ? cpu_wdata : line_data;
                  if (cpu_we) begin
                     c_en      = 1'b1;
                     c_state   = LS_EXC;
                     c_tag     = cpu_tag;
                     c_data_en = 1'b1;
                  end
                  st_d = FS_RESP;
               end else if (need_wb) begin
                  st_d = FS_WBACK;
               end else begin
                  st_d = FS_MISS;
               end
            end
         end
         FS_WBACK: begin
            if (snp_valid) begin
               if (pend_hit) st_d = FS_IDLE;
            end else begin
               bus_req   = 1'b1;
               bus_cmd   = BC_WBACK;
               bus_addr  = {line_tag, cpu_idx};
               bus_wdata = line_data;
               if (bus_gnt) begin
                  c_en    = 1'b1;
                  c_state = LS_INV;
                  st_d    = FS_MISS;
               end
            end
         end
         FS_MISS: begin
            if (snp_valid) begin
               if (pend_hit) st_d = FS_IDLE;
            end else begin
               bus_req  = 1'b1;
               bus_cmd  = cpu_we ? BC_WRMISS : BC_RDMISS;
               bus_addr = cpu_addr;
               if (bus_gnt) begin
                  c_en      = 1'b1;
                  c_tag     = cpu_tag;
                  c_data_en = 1'b1;
                  c_data    = cpu_we ? cpu_wdata : bus_rdata;
                  c_state   = cpu_we ? LS_EXC : LS_SHD;
                  rd_load   = 1'b1;
                  rdata_d   = cpu_we ? cpu_wdata : bus_rdata;
                  st_d      = FS_RESP;
               end
            end
         end
         default: st_d = FS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         rdata_q <= '0;
      end else begin
         st_q <= st_d;
         if (rd_load) rdata_q <= rdata_d;
      end
   end

   assign cpu_done  = (st_q == FS_RESP);
   assign cpu_rdata = rdata_q;
endmodule

// File: rtl/msi_snoop_cache.sv
`timescale 1ns/1ps
module msi_snoop_cache
   import msi_pkg::*;
#(
   parameter int AW            = 8,
   parameter int IDXW          = 3,
   parameter int DW            = 16,
   parameter bit CLEAR_PAYLOAD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_done,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic [1:0]    bus_cmd,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          snp_valid,
   input  logic          snp_wr,
   input  logic [AW-1:0] snp_addr,
   output logic          snp_abort,
   output logic [DW-1:0] snp_data
);
   localparam int TAGW = AW - IDXW;

   generate
      if (IDXW < 1 || IDXW >= AW) begin : g_bad_idx
         $error("msi_snoop_cache: IDXW must lie in 1..AW-1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("msi_snoop_cache: DW must be at least 1");
      end
      if (IDXW > 10) begin : g_bad_depth
         $error("msi_snoop_cache: IDXW above 10 makes the line store too large");
      end
   endgenerate

   logic [IDXW-1:0] cpu_idx, snp_idx;
   logic [TAGW-1:0] snp_tag;
   assign cpu_idx = cpu_addr[IDXW-1:0];
   assign snp_idx = snp_addr[IDXW-1:0];
   assign snp_tag = snp_addr[AW-1:IDXW];

   line_st_t        a_state, b_state, s_state, c_state;
   logic [TAGW-1:0] a_tag, b_tag, c_tag;
   logic [DW-1:0]   a_data, b_data, c_data;
   logic            s_en, c_en, c_data_en;
   bus_cmd_t        cmd;

   msi_line_store #(
      .IDXW(IDXW), .TAGW(TAGW), .DW(DW), .CLEAR_PAYLOAD(CLEAR_PAYLOAD)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(cpu_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
      .b_idx(snp_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
      .s_en(s_en), .s_idx(snp_idx), .s_state(s_state),
      .c_en(c_en), .c_idx(cpu_idx), .c_state(c_state), .c_tag(c_tag),
      .c_data_en(c_data_en), .c_data(c_data)
   );

   msi_snoop_unit #(.TAGW(TAGW), .DW(DW)) u_snoop (
      .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_tag(snp_tag),
      .line_state(b_state), .line_tag(b_tag), .line_data(b_data),
      .abort(snp_abort), .data(snp_data),
      .upd_en(s_en), .upd_state(s_state)
   );

   msi_req_fsm #(.AW(AW), .IDXW(IDXW), .TAGW(TAGW), .DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
      .line_state(a_state), .line_tag(a_tag), .line_data(a_data),
      .snp_valid(snp_valid), .snp_upd_en(s_en), .snp_idx(snp_idx),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .c_en(c_en), .c_state(c_state), .c_tag(c_tag),
      .c_data_en(c_data_en), .c_data(c_data)
   );

   assign bus_cmd = cmd;
endmodule

// File: rtl/msi_snoop_cache_chk.sv
`timescale 1ns/1ps
module msi_snoop_cache_chk #(
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_done,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic [1:0]    bus_cmd,
   input logic [AW-1:0] bus_addr,
   input logic          snp_valid,
   input logic          snp_abort
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!cpu_done && !bus_req && !snp_abort));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R5
   wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == 2'd3) |=>
         (snp_valid || (bus_req && bus_cmd != 2'd3)));

   // R7
   abort_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |-> snp_valid);

   // R10
   snoop_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !bus_req);

   // R12
   cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |-> (bus_cmd == 2'd0));

   // R12
   cmd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_cmd != 2'd0));

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!snp_valid && $past(bus_req && !bus_gnt && !snp_valid)) |->
         (bus_req && bus_cmd == $past(bus_cmd) && bus_addr == $past(bus_addr)));
endmodule

bind msi_snoop_cache msi_snoop_cache_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done),
   .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
   .bus_addr(bus_addr), .snp_valid(snp_valid), .snp_abort(snp_abort)
);

// File: tb/msi_snoop_cache_test.sv
`timescale 1ns/1ps
module msi_snoop_cache_test;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NV = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_done;
   logic          bus_req, bus_gnt;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          snp_valid = 1'b0, snp_wr = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_abort;
   logic [DW-1:0] snp_data;
   logic          gnt_en = 1'b1;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   msi_snoop_cache uut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_addr(snp_addr),
      .snp_abort(snp_abort), .snp_data(snp_data)
   );

   // memory and arbiter model
   logic [DW-1:0] mem [1 << AW];
   assign bus_gnt   = bus_req & gnt_en;
   assign bus_rdata = mem[bus_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < (1 << AW); i++) mem[i] <= DW'(i * 3 + 7);
      end else begin
         if (bus_req && bus_gnt && bus_cmd == 2'd3) mem[bus_addr] <= bus_wdata;
         if (snp_valid && snp_abort) mem[snp_addr] <= snp_data;
      end
   end

   // {req, we, addr, wdata, expected rdata, expected bus commands (first in [1:0])}
   localparam logic [48:0] VEC [NV] = '{
      {4'd2, 1'b0, 8'h10, 16'h0000, 16'h0037, 4'h1},  // R2 read miss from Invalid
      {4'd4, 1'b0, 8'h10, 16'h0000, 16'h0037, 4'h0},  // R4 read hit Shared
      {4'd3, 1'b1, 8'h10, 16'hAAAA, 16'h0000, 4'h2},  // R3 write to Shared
      {4'd4, 1'b0, 8'h10, 16'h0000, 16'hAAAA, 4'h0},  // R4 read hit Exclusive
      {4'd4, 1'b1, 8'h10, 16'hBBBB, 16'h0000, 4'h0},  // R4 write hit Exclusive
      {4'd5, 1'b0, 8'h18, 16'h0000, 16'h004F, 4'h7},  // R5 dirty victim, read
      {4'd6, 1'b0, 8'h10, 16'h0000, 16'hBBBB, 4'h1},  // R6 silent Shared victim
      {4'd3, 1'b1, 8'h21, 16'h1234, 16'h0000, 4'h2},  // R3 write to Invalid
      {4'd5, 1'b1, 8'h29, 16'h5678, 16'h0000, 4'hB},  // R5 dirty victim, write
      {4'd5, 1'b0, 8'h21, 16'h0000, 16'h1234, 4'h7},  // R5 dirty victim, read
      {4'd6, 1'b0, 8'h29, 16'h0000, 16'h5678, 4'h1}   // R6 silent Shared victim
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic start_op(input logic we, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
   endtask

   task automatic finish_op(output logic [DW-1:0] rd, output logic [3:0] log);
      int n = 0;
      bit done = 0;
      log = 4'h0; rd = '0;
      for (int k = 0; k < 60 && !done; k++) begin
         @(negedge clk);
         if (bus_req && bus_gnt) begin
            if (n < 2) log = log | (4'(bus_cmd) << (2 * n));
            else       log = 4'hF;
            n++;
         end
         if (cpu_done) begin
            rd = cpu_rdata;
            done = 1;
         end
      end
      cpu_req = 1'b0;
      if (!done) begin
         checks++; fails++;
         $display("FAIL R4 access never completed: actual 0 expected 1");
      end
   endtask

   task automatic do_op(input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output logic [3:0] log);
      start_op(we, a, wd);
      finish_op(rd, log);
   endtask

   task automatic snoop(input string req, input logic wr, input logic [AW-1:0] a,
                        input logic exp_abort, input logic [DW-1:0] exp_data);
      @(negedge clk);
      snp_valid = 1'b1; snp_wr = wr; snp_addr = a;
      #2;
      check(req, "snoop abort", 32'(snp_abort), 32'(exp_abort));
      if (exp_abort) check(req, "snoop data", 32'(snp_data), 32'(exp_data));
      @(negedge clk);
      snp_valid = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      logic [3:0]    lg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "cpu_done", 32'(cpu_done), 32'd0);
      check("R1", "bus_req", 32'(bus_req), 32'd0);
      check("R1", "snp_abort", 32'(snp_abort), 32'd0);
      check("R1", "bus_cmd", 32'(bus_cmd), 32'd0);
      snoop("R1", 1'b1, 8'h10, 1'b0, '0);
      snoop("R9", 1'b0, 8'h05, 1'b0, '0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         logic [48:0] e;
         string tag;
         e = VEC[v];
         tag = $sformatf("R%0d", e[48:45]);
         do_op(e[44], e[43:36], e[35:20], rd, lg);
         check(tag, $sformatf("vector %0d bus commands", v), 32'(lg), 32'(e[3:0]));
         if (!e[44])
            check(tag, $sformatf("vector %0d read data", v), 32'(rd), 32'(e[19:4]));
      end

      // R7 snooped read miss on Exclusive
      do_op(1'b1, 8'h32, 16'hCAFE, rd, lg);
      check("R3", "write miss cmds", 32'(lg), 32'h2);
      snoop("R7", 1'b0, 8'h32, 1'b1, 16'hCAFE);
      do_op(1'b0, 8'h32, '0, rd, lg);
      check("R7", "read after downgrade cmds", 32'(lg), 32'h0);
      check("R7", "read after downgrade data", 32'(rd), 32'hCAFE);
      snoop("R9", 1'b0, 8'h32, 1'b0, '0);
      do_op(1'b1, 8'h32, 16'hBEEF, rd, lg);
      check("R7", "write after downgrade cmds", 32'(lg), 32'h2);

      // R8 snooped write miss on Exclusive
      snoop("R8", 1'b1, 8'h32, 1'b1, 16'hBEEF);
      do_op(1'b0, 8'h32, '0, rd, lg);
      check("R8", "read after invalidate cmds", 32'(lg), 32'h1);
      check("R8", "read after invalidate data", 32'(rd), 32'hBEEF);

      // R8 snooped write miss on Shared
      snoop("R8", 1'b1, 8'h32, 1'b0, '0);
      do_op(1'b0, 8'h32, '0, rd, lg);
      check("R8", "shared invalidate cmds", 32'(lg), 32'h1);

      // R9 snoop to other tag on same index
      snoop("R9", 1'b1, 8'h3A, 1'b0, '0);
      do_op(1'b0, 8'h32, '0, rd, lg);
      check("R9", "line kept cmds", 32'(lg), 32'h0);
      check("R9", "line kept data", 32'(rd), 32'hBEEF);

      // R10 / R11 snoop during a pending write-back
      do_op(1'b1, 8'h3C, 16'h7777, rd, lg);
      check("R3", "write miss cmds", 32'(lg), 32'h2);
      gnt_en = 1'b0;
      start_op(1'b0, 8'h44, '0);
      @(negedge clk);
      check("R5", "pending write-back req", 32'(bus_req), 32'd1);
      check("R5", "pending write-back cmd", 32'(bus_cmd), 32'd3);
      check("R5", "pending write-back addr", 32'(bus_addr), 32'h3C);
      @(negedge clk);
      check("R12", "held req", 32'(bus_req), 32'd1);
      check("R12", "held addr", 32'(bus_addr), 32'h3C);
      snp_valid = 1'b1; snp_wr = 1'b1; snp_addr = 8'h3C;
      #2;
      check("R10", "req dropped under snoop", 32'(bus_req), 32'd0);
      check("R8", "pending victim abort", 32'(snp_abort), 32'd1);
      check("R8", "pending victim data", 32'(snp_data), 32'h7777);
      @(negedge clk);
      snp_valid = 1'b0;
      gnt_en = 1'b1;
      finish_op(rd, lg);
      check("R11", "restart skips write-back", 32'(lg), 32'h1);
      check("R11", "restart read data", 32'(rd), 32'h00D3);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule